// File: doc/BRIEF.md
# Fair Release-When-Done Bus Requester

This block lets a local bus master win ownership of a shared backplane bus on a single request level. It also takes part in the bus-grant daisy chain. The local master raises a request. When the grant arrives and no other master still holds the bus, the block asserts the bus-busy line and reports ownership to the local master. It keeps the bus until the local master says its transfer sequence is finished. A read-modify-write pair keeps ownership across both halves, because a lock input masks the finish signal while it is high.

Requests are fair. After each tenure the block stays silent until it has seen the shared request line go idle, so every master on the level gets a turn. A grant arriving while the block is not requesting is passed down the chain. A grant that has started to pass keeps passing until it ends. The block takes a grant only when the grant starts while the block is already requesting.

All bus-side signals are logical, active-high. Pad inversion for the low-true backplane lines sits outside this block. The three bus inputs pass through a synchronizer of `SYNC_STAGES` flops before any decision uses them.

Top module: `vme_fair_requester`

## Requirements
- R1: While `rst` is high, and on the first clock after it, all four outputs are low.
- R2: With the block idle and the shared request line seen low, raising `loc_req` drives `bus_br_out` high on the next clock edge.
- R3: While requesting, a fresh grant with `bus_bbsy_line` low raises `bus_bbsy_out` and `loc_grant` together, `SYNC_STAGES`+1 edges after the bus inputs change. `bus_bgout` stays low while this happens.
- R4: While requesting, a grant is held but not used while `bus_bbsy_line` is high. Ownership follows `SYNC_STAGES`+1 edges after that line falls.
- R5: In the idle and fairness-wait states, `bus_bgout` follows `bus_bgin` with a delay of `SYNC_STAGES`+1 edges, both when it rises and when it falls.
- R6: A grant already being passed on keeps passing even if a request starts during it. The block does not take that grant. It takes the next grant that rises after the passed one has ended. `bus_bbsy_out` and `bus_bgout` are never high together.
- R7: Once owned, the bus stays owned (`bus_bbsy_out`, `bus_br_out`, `loc_grant` high) for any number of cycles until finish is signalled.
- R8: While `loc_rmw` is high, `loc_done` is ignored and ownership continues.
- R9: On the edge that samples `loc_done` high with `loc_rmw` low, `bus_bbsy_out`, `loc_grant` and `bus_br_out` all go low.
- R10: After a release, `bus_br_out` stays low until the incoming grant has been seen low and the shared request line has been seen low. The request goes out two edges after the synchronized request line is seen low, provided `loc_req` is high.
- R11: Bus inputs reach the decision logic only through `SYNC_STAGES` register stages (default 2). No output reacts to a bus input change within `SYNC_STAGES` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_req | input | 1 | Local master wants the bus (sampled in idle) |
| loc_done | input | 1 | Local transfer sequence finished |
| loc_rmw | input | 1 | Read-modify-write lock; masks `loc_done` |
| bus_bgin | input | 1 | Incoming grant from the daisy chain (async) |
| bus_br_line | input | 1 | Shared request line as seen on the bus (async) |
| bus_bbsy_line | input | 1 | Bus-busy driven by another master (async) |
| bus_br_out | output | 1 | This card's bus request |
| bus_bbsy_out | output | 1 | This card's bus-busy |
| bus_bgout | output | 1 | Grant passed to the next card |
| loc_grant | output | 1 | Ownership indication to the local master |

## Verification
The bench drives the grant in four ways: a grant with no request, a grant while another master is still busy, a grant while the bus is free, and a grant that was already passing when a request started. Together these separate pass-through from capture, and capture from waiting on a busy bus. Finish is tried with the lock high and then low, which shows that read-modify-write masking works and that release takes one edge. A second request made while the shared request line stays high, and then made after the line clears, shows fairness at the exact edge the request goes out. Checks placed at one edge before and at the edge of each expected bus reaction pin down the synchronizer depth.

// File: rtl/vfr_pkg.sv
package vfr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_FAIR = 3'd1,
    ST_REQ       = 3'd2,
    ST_OWN       = 3'd3,
    ST_RELEASE   = 3'd4
  } arb_state_t;
endpackage

// File: rtl/vfr_sync.sv
module vfr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= async_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[g] <= '0;
      else     pipe[g] <= pipe[g-1];
    end
  end

  assign sync_out = pipe[STAGES-1];

  initial assert (STAGES >= 2) else $error("assert_min_stages_R11: need two or more stages");
endmodule

// File: rtl/vfr_fsm.sv
module vfr_fsm
  import vfr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic loc_req,
  input  logic loc_done,
  input  logic loc_rmw,
  input  logic s_bgin,
  input  logic s_brline,
  input  logic s_bbsyline,
  output logic br_out,
  output logic bbsy_out,
  output logic bgout,
  output logic loc_grant
);
  arb_state_t state, state_n;
  logic pass_n;

  // A grant passes when idle/waiting, or keeps passing once started.
  always_comb begin
    pass_n = s_bgin && (bgout || state == ST_IDLE || state == ST_WAIT_FAIR);
  end

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:      if (loc_req) state_n = ST_REQ;
      ST_WAIT_FAIR: if (!s_brline) state_n = ST_IDLE;
      ST_REQ:       if (s_bgin && !bgout && !s_bbsyline) state_n = ST_OWN;
      ST_OWN:       if (loc_done && !loc_rmw) state_n = ST_RELEASE;
      ST_RELEASE:   if (!s_bgin) state_n = ST_WAIT_FAIR;
      default:      state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      br_out    <= 1'b0;
      bbsy_out  <= 1'b0;
      loc_grant <= 1'b0;
      bgout     <= 1'b0;
    end else begin
      state     <= state_n;
      br_out    <= (state_n == ST_REQ) || (state_n == ST_OWN);
      bbsy_out  <= (state_n == ST_OWN);
      loc_grant <= (state_n == ST_OWN);
      bgout     <= pass_n;
    end
  end

  assert_take_fresh_grant_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(bbsy_out) |-> ($past(s_bgin) && !$past(s_bbsyline) && !$past(bgout)));
  assert_wait_busy_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(loc_grant) |-> !$past(s_bbsyline));
  assert_pass_start_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(bgout) |-> ($past(s_bgin) && !$past(br_out)));
  assert_no_grab_and_pass_R6: assert property (@(posedge clk) disable iff (rst)
    !(bbsy_out && bgout));
  assert_own_keeps_req_R7: assert property (@(posedge clk) disable iff (rst)
    bbsy_out |-> (br_out && loc_grant));
  assert_rmw_lock_R8: assert property (@(posedge clk) disable iff (rst)
    (loc_grant && loc_rmw) |=> loc_grant);
  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    (loc_grant && loc_done && !loc_rmw) |=> (!bbsy_out && !loc_grant && !br_out));
  assert_fair_request_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(br_out) |-> ($past(state) == ST_IDLE));
endmodule

// File: rtl/vme_fair_requester.sv
module vme_fair_requester #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic loc_req,
  input  logic loc_done,
  input  logic loc_rmw,
  input  logic bus_bgin,
  input  logic bus_br_line,
  input  logic bus_bbsy_line,
  output logic bus_br_out,
  output logic bus_bbsy_out,
  output logic bus_bgout,
  output logic loc_grant
);
  localparam int NUM_ASYNC = 3;

  logic [NUM_ASYNC-1:0] raw_in, synced;

  assign raw_in = {bus_bbsy_line, bus_br_line, bus_bgin};

  vfr_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (raw_in),
    .sync_out (synced)
  );

  vfr_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .loc_req    (loc_req),
    .loc_done   (loc_done),
    .loc_rmw    (loc_rmw),
    .s_bgin     (synced[0]),
    .s_brline   (synced[1]),
    .s_bbsyline (synced[2]),
    .br_out     (bus_br_out),
    .bbsy_out   (bus_bbsy_out),
    .bgout      (bus_bgout),
    .loc_grant  (loc_grant)
  );
endmodule

// File: tb/vme_fair_requester_test.sv
module vme_fair_requester_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loc_req = 0, loc_done = 0, loc_rmw = 0;
  logic bus_bgin = 0, bus_br_line = 0, bus_bbsy_line = 0;
  logic bus_br_out, bus_bbsy_out, bus_bgout, loc_grant;

  int tests = 0;
  int fails = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  vme_fair_requester uut (
    .clk(clk), .rst(rst), .loc_req(loc_req), .loc_done(loc_done), .loc_rmw(loc_rmw),
    .bus_bgin(bus_bgin), .bus_br_line(bus_br_line), .bus_bbsy_line(bus_bbsy_line),
    .bus_br_out(bus_br_out), .bus_bbsy_out(bus_bbsy_out), .bus_bgout(bus_bgout),
    .loc_grant(loc_grant)
  );

  // Behavioural reference: 0 idle, 1 fairness wait, 2 asking, 3 owner, 4 letting go.
  int  m_mode = 0;
  bit  m_pass = 0;
  bit  dly_bg[$], dly_br[$], dly_by[$];

  task automatic model_clear();
    m_mode = 0; m_pass = 0;
    dly_bg = '{0, 0}; dly_br = '{0, 0}; dly_by = '{0, 0};
  endtask

  initial model_clear();

  always @(posedge clk) begin
    if (rst) model_clear();
    else begin
      bit g, l, b, np;
      g = dly_bg[0]; l = dly_br[0]; b = dly_by[0];
      np = g && (m_pass || m_mode <= 1);
      if (m_mode == 0 && loc_req) m_mode = 2;
      else if (m_mode == 1 && !l) m_mode = 0;
      else if (m_mode == 2 && g && !m_pass && !b) m_mode = 3;
      else if (m_mode == 3 && loc_done && !loc_rmw) m_mode = 4;
      else if (m_mode == 4 && !g) m_mode = 1;
      m_pass = np;
      void'(dly_bg.pop_front()); dly_bg.push_back(bus_bgin);
      void'(dly_br.pop_front()); dly_br.push_back(bus_br_line);
      void'(dly_by.pop_front()); dly_by.push_back(bus_bbsy_line);
    end
  end

  // Per-cycle comparison against the model, away from the edge.
  always @(posedge clk) begin
    #2;
    tests++;
    if (bus_br_out   !== (m_mode == 2 || m_mode == 3) ||
        bus_bbsy_out !== (m_mode == 3) || loc_grant !== (m_mode == 3) ||
        bus_bgout    !== m_pass) begin
      fails++;
      $display("FAIL %s model cycle: got br=%b bbsy=%b bgout=%b grant=%b, expected br=%b bbsy=%b bgout=%b grant=%b",
               phase, bus_br_out, bus_bbsy_out, bus_bgout, loc_grant,
               (m_mode == 2 || m_mode == 3), (m_mode == 3), m_pass, (m_mode == 3));
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(3);
    chk("R1", "br in reset", bus_br_out, 0);
    chk("R1", "bbsy in reset", bus_bbsy_out, 0);
    rst = 0;
    step(1);
    chk("R1", "grant after reset", loc_grant, 0);
    chk("R1", "bgout after reset", bus_bgout, 0);

    // Pass-through while idle, and synchronizer depth
    phase = "R5";
    bus_bgin = 1;
    step(2); chk("R11", "bgout before sync delay", bus_bgout, 0);
    step(1); chk("R5", "bgout follows bgin", bus_bgout, 1);
    bus_bgin = 0;
    step(2); chk("R11", "bgout held before sync delay", bus_bgout, 1);
    step(1); chk("R5", "bgout falls with bgin", bus_bgout, 0);

    // Request, then a grant while another master is still busy
    phase = "R2";
    loc_req = 1; bus_br_line = 1;
    step(1); chk("R2", "request out", bus_br_out, 1);
    loc_req = 0;
    phase = "R4";
    bus_bgin = 1; bus_bbsy_line = 1;
    step(5);
    chk("R4", "no ownership while busy", loc_grant, 0);
    chk("R4", "held grant not passed", bus_bgout, 0);
    phase = "R3";
    bus_bbsy_line = 0;
    step(2); chk("R3", "not owned before sync delay", bus_bbsy_out, 0);
    step(1);
    chk("R3", "bbsy taken", bus_bbsy_out, 1);
    chk("R3", "grant to local", loc_grant, 1);
    chk("R3", "grant not passed", bus_bgout, 0);

    // Hold until done, lock masking done
    phase = "R7";
    step(10); chk("R7", "still owned", bus_bbsy_out, 1);
    phase = "R8";
    loc_rmw = 1; loc_done = 1;
    step(4); chk("R8", "done masked by lock", loc_grant, 1);
    phase = "R9";
    loc_rmw = 0;
    step(1);
    chk("R9", "bbsy released", bus_bbsy_out, 0);
    chk("R9", "grant dropped", loc_grant, 0);
    chk("R9", "request dropped", bus_br_out, 0);
    loc_done = 0;

    // Fairness: shared request line still high
    phase = "R10";
    loc_req = 1;
    bus_bgin = 0;
    step(8); chk("R10", "no request while line busy", bus_br_out, 0);
    bus_br_line = 0;
    step(3); chk("R10", "no request before idle reached", bus_br_out, 0);
    step(1); chk("R10", "request after line cleared", bus_br_out, 1);
    loc_req = 0;
    bus_bgin = 1;
    step(3); chk("R3", "second ownership", loc_grant, 1);
    loc_done = 1; step(1); loc_done = 0;
    bus_bgin = 0;
    step(8);

    // Grant already passing when a request starts
    phase = "R6";
    bus_bgin = 1;
    step(4); chk("R5", "passing in idle", bus_bgout, 1);
    loc_req = 1;
    step(1); loc_req = 0;
    step(2);
    chk("R6", "pass continues", bus_bgout, 1);
    chk("R6", "passed grant not taken", loc_grant, 0);
    chk("R6", "request raised", bus_br_out, 1);
    bus_bgin = 0;
    step(3); chk("R6", "pass ends", bus_bgout, 0);
    bus_bgin = 1;
    step(3);
    chk("R6", "next grant taken", loc_grant, 1);
    chk("R6", "next grant not passed", bus_bgout, 0);
    loc_done = 1; step(1); loc_done = 0;
    chk("R9", "final release", bus_bbsy_out, 0);
    bus_bgin = 0;
    step(6);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule